// File: doc/BRIEF.md
# Serializer Bring-Up Sequencer over a Two-Wire Bus

This block configures a video serializer chip after reset, with no software involved. While the system is in reset, and until the supplies report good, it holds the chip's register-interface reset line low and leaves the bus untouched. Once `pwr_good` rises, it releases that line and runs a fixed script of single-byte register accesses over an I2C bus it drives as master. The script runs in this order:

1. Take the chip out of power-down.
2. Program three mode registers from parameters.
3. Read back the identification bytes and compare them with expected constants.

The result appears on `done` or `error`. The error code names the step that failed. The captured identification bytes stay on the output ports.

The bit-level master drives open-drain enables for SCL and SDA, with no clock stretching and no arbitration. One SCL period is four quarter-periods of `QTR_CYC` system clocks each. The default of 250 quarter-period clocks gives 100 kHz from a 100 MHz clock.

Top module: `txcfg_bringup`

## Requirements
- R1: `tgt_rst_n` is low during reset and stays low until `pwr_good` is seen high. It then stays high until reset. While it is low, neither `scl_oe` nor `sda_oe` is asserted.
- R2: Each SCL period lasts 4*QTR_CYC system clocks. SDA changes only while SCL is low, except in START and STOP conditions.
- R3: Every address byte carries the 7-bit target address 0x38 followed by the direction bit: 0x70 for a write, 0x71 for a read.
- R4: The first transaction writes the data byte 0x01 to sub-address 0x08, which clears power-down.
- R5: Next come three writes in this order: MODE_A to 0x08, MODE_B to 0x09 and MODE_C to 0x0A. Each write is START, address, sub-address, one data byte, STOP.
- R6: A read is START, address with write bit, sub-address, repeated START, address with read bit, one data byte answered with NACK, STOP.
- R7: Reads cover sub-addresses 0x00, 0x01 and 0x02, in that order. `vendor_id` = {byte at 0x01, byte at 0x00} and `device_id` = byte at 0x02.
- R8: If `vendor_id` differs from EXP_VID (default 0x014C), `error` rises with code 8. Otherwise, if `device_id` differs from EXP_DID, `error` rises with code 9.
- R9: A missing ACK on any address or written byte ends the script at once. The block issues a STOP and raises `error` with code equal to the step number plus one (steps 0..6 in the order of R4, R5 and R7). No later step runs.
- R10: `done` rises only when every step completed with all ACKs and the ID check passed. `done` and `error` are never high together and both hold until reset. Both bus lines are released when either flag is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pwr_good | input | 1 | Supplies stable indication |
| sda_in | input | 1 | Sensed level of the SDA line |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| tgt_rst_n | output | 1 | Target register-interface reset, active low |
| done | output | 1 | Bring-up completed and verified |
| error | output | 1 | Bring-up failed |
| err_code | output | 4 | Failing step plus one, or 8/9 for an ID mismatch |
| vendor_id | output | 16 | Captured vendor identification |
| device_id | output | 8 | Captured device identification |

## Verification
The assertions assume nobody else holds SCL, so a released SCL enable means SCL is high. They also assume the target changes SDA only while SCL is low and drives it only in acknowledge and read-data slots. The bench target model meets this: it acts only on SCL falling edges seen at the negative clock edge, releases SDA before any master START or STOP, and never stretches the clock. `pwr_good` is raised only after a quiet interval in which the bench confirms the bus stays idle.

// File: rtl/txcfg_pkg.sv
package txcfg_pkg;
   typedef enum logic [1:0] {
      OP_START = 2'd0,
      OP_STOP  = 2'd1,
      OP_WRITE = 2'd2,
      OP_READ  = 2'd3
   } i2c_op_e;

   localparam int          ERR_W       = 4;
   localparam logic [7:0]  PWR_ON_BYTE = 8'h01;
   localparam logic [ERR_W-1:0] ERR_VID = 4'd8;
   localparam logic [ERR_W-1:0] ERR_DID = 4'd9;
   localparam int          NUM_STEPS   = 7;
   localparam int          FIRST_READ  = 4;
endpackage

// File: rtl/txcfg_i2c_engine.sv
module txcfg_i2c_engine
   import txcfg_pkg::*;
#(
   parameter int QTR_CYC = 250
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cmd_valid,
   input  i2c_op_e    cmd_op,
   input  logic [7:0] cmd_byte,
   output logic       busy,
   output logic       done,
   output logic       ack_ok,
   output logic [7:0] rx_byte,
   input  logic       sda_in,
   output logic       scl_oe,
   output logic       sda_oe
);
   localparam int QW = (QTR_CYC > 1) ? $clog2(QTR_CYC) : 1;

   typedef enum logic [1:0] {E_IDLE, E_START, E_BIT, E_STOP} eng_st_e;

   eng_st_e        st;
   logic [QW-1:0]  qcnt;
   logic [1:0]     phase;
   logic [3:0]     bitn;
   logic [7:0]     sh;
   logic           is_rd;
   logic           tick;
   logic           enter;

   initial assert (QTR_CYC >= 2) else $error("QTR_CYC must be at least 2");

   assign tick    = (qcnt == QW'(QTR_CYC - 1));
   assign enter   = (qcnt == '0);
   assign busy    = (st != E_IDLE);
   assign rx_byte = sh;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st     <= E_IDLE;
         qcnt   <= '0;
         phase  <= '0;
         bitn   <= '0;
         sh     <= '0;
         is_rd  <= 1'b0;
         done   <= 1'b0;
         ack_ok <= 1'b0;
         scl_oe <= 1'b0;
         sda_oe <= 1'b0;
      end else begin
         done <= 1'b0;
         if (st == E_IDLE) begin
            qcnt  <= '0;
            phase <= '0;
            if (cmd_valid) begin
               bitn <= '0;
               case (cmd_op)
                  OP_START: st <= E_START;
                  OP_STOP:  st <= E_STOP;
                  OP_WRITE: begin st <= E_BIT; sh <= cmd_byte; is_rd <= 1'b0; end
                  default:  begin st <= E_BIT; sh <= '0;       is_rd <= 1'b1; end
               endcase
            end
         end else begin
            qcnt <= tick ? '0 : qcnt + 1'b1;
            // line updates at the first clock of each quarter
            if (enter) begin
               case (st)
                  E_START: case (phase)
                     2'd0: sda_oe <= 1'b0;
                     2'd1: scl_oe <= 1'b0;
                     2'd2: sda_oe <= 1'b1;
                     default: scl_oe <= 1'b1;
                  endcase
                  E_BIT: case (phase)
                     2'd0: sda_oe <= (is_rd || bitn == 4'd8) ? 1'b0 : ~sh[7];
                     2'd1: scl_oe <= 1'b0;
                     2'd3: scl_oe <= 1'b1;
                     default: ;
                  endcase
                  default: case (phase)
                     2'd0: sda_oe <= 1'b1;
                     2'd1: scl_oe <= 1'b0;
                     2'd2: sda_oe <= 1'b0;
                     default: ;
                  endcase
               endcase
            end
            if (tick) begin
               phase <= phase + 1'b1;
               if (st == E_BIT && phase == 2'd2) begin
                  if (bitn == 4'd8) ack_ok <= ~sda_in;
                  else              sh     <= {sh[6:0], is_rd ? sda_in : 1'b0};
               end
               if (phase == 2'd3) begin
                  if (st == E_BIT && bitn != 4'd8) begin
                     bitn <= bitn + 1'b1;
                  end else begin
                     st   <= E_IDLE;
                     done <= 1'b1;
                  end
               end
            end
         end
      end
   end

   AST_CMD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |-> !busy); // R6

   AST_SDA_STILL_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (st == E_BIT && $past(st) == E_BIT && !scl_oe && !$past(scl_oe)) |-> $stable(sda_oe)); // R2
endmodule

// File: rtl/txcfg_script.sv
module txcfg_script
   import txcfg_pkg::*;
#(
   parameter logic [6:0]  TGT_ADDR  = 7'h38,
   parameter logic [7:0]  MODE_A    = 8'h35,
   parameter logic [7:0]  MODE_B    = 8'h16,
   parameter logic [7:0]  MODE_C    = 8'h80,
   parameter logic [15:0] EXP_VID   = 16'h014C,
   parameter logic [7:0]  EXP_DID   = 8'h10,
   parameter bit          CHECK_DID = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             go,
   output logic             cmd_valid,
   output i2c_op_e          cmd_op,
   output logic [7:0]       cmd_byte,
   input  logic             eng_done,
   input  logic             eng_ack,
   input  logic [7:0]       eng_rx,
   output logic             done,
   output logic             error,
   output logic [ERR_W-1:0] err_code,
   output logic [15:0]      vendor_id,
   output logic [7:0]       device_id
);
   typedef enum logic [2:0] {
      SQ_IDLE, SQ_ISSUE, SQ_WAIT, SQ_ABORT, SQ_ABWAIT, SQ_CHECK, SQ_DONE, SQ_FAIL
   } seq_st_e;

   seq_st_e    st;
   logic [2:0] step;
   logic [2:0] idx;
   logic [2:0] last_idx;
   logic       rd_step;
   logic [7:0] sub_addr;
   logic [7:0] wr_data;
   i2c_op_e    tbl_op;
   logic [7:0] tbl_byte;
   logic [7:0] id_lo, id_hi, id_dev;
   logic       vid_ok, did_ok;

   always_comb begin
      rd_step  = (step >= 3'(FIRST_READ));
      last_idx = rd_step ? 3'd6 : 3'd4;
      case (step)
         3'd0, 3'd1: sub_addr = 8'h08;
         3'd2:       sub_addr = 8'h09;
         3'd3:       sub_addr = 8'h0A;
         3'd4:       sub_addr = 8'h00;
         3'd5:       sub_addr = 8'h01;
         default:    sub_addr = 8'h02;
      endcase
      case (step)
         3'd0:    wr_data = PWR_ON_BYTE;
         3'd1:    wr_data = MODE_A;
         3'd2:    wr_data = MODE_B;
         default: wr_data = MODE_C;
      endcase
      tbl_byte = 8'h00;
      case (idx)
         3'd0: tbl_op = OP_START;
         3'd1: begin tbl_op = OP_WRITE; tbl_byte = {TGT_ADDR, 1'b0}; end
         3'd2: begin tbl_op = OP_WRITE; tbl_byte = sub_addr; end
         3'd3: begin
            tbl_op   = rd_step ? OP_START : OP_WRITE;
            tbl_byte = wr_data;
         end
         3'd4: begin
            tbl_op   = rd_step ? OP_WRITE : OP_STOP;
            tbl_byte = {TGT_ADDR, 1'b1};
         end
         3'd5: tbl_op = OP_READ;
         default: tbl_op = OP_STOP;
      endcase
   end

   assign cmd_valid = (st == SQ_ISSUE) || (st == SQ_ABORT);
   assign cmd_op    = (st == SQ_ABORT) ? OP_STOP : tbl_op;
   assign cmd_byte  = tbl_byte;
   assign vendor_id = {id_hi, id_lo};
   assign device_id = id_dev;
   assign vid_ok    = ({id_hi, id_lo} == EXP_VID);

   generate
      if (CHECK_DID) begin : g_did_chk
         assign did_ok = (id_dev == EXP_DID);
      end else begin : g_did_skip
         assign did_ok = 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st       <= SQ_IDLE;
         step     <= '0;
         idx      <= '0;
         id_lo    <= '0;
         id_hi    <= '0;
         id_dev   <= '0;
         done     <= 1'b0;
         error    <= 1'b0;
         err_code <= '0;
      end else begin
         case (st)
            SQ_IDLE:  if (go) st <= SQ_ISSUE;
            SQ_ISSUE: st <= SQ_WAIT;
            SQ_WAIT: if (eng_done) begin
               if (tbl_op == OP_WRITE && !eng_ack) begin
                  err_code <= ERR_W'(step) + 1'b1;
                  st       <= SQ_ABORT;
               end else begin
                  if (tbl_op == OP_READ) begin
                     case (step)
                        3'd4:    id_lo  <= eng_rx;
                        3'd5:    id_hi  <= eng_rx;
                        default: id_dev <= eng_rx;
                     endcase
                  end
                  if (idx == last_idx) begin
                     idx <= '0;
                     if (step == 3'(NUM_STEPS - 1)) begin
                        st <= SQ_CHECK;
                     end else begin
                        step <= step + 1'b1;
                        st   <= SQ_ISSUE;
                     end
                  end else begin
                     idx <= idx + 1'b1;
                     st  <= SQ_ISSUE;
                  end
               end
            end
            SQ_ABORT:  st <= SQ_ABWAIT;
            SQ_ABWAIT: if (eng_done) begin
               st    <= SQ_FAIL;
               error <= 1'b1;
            end
            SQ_CHECK: begin
               if (!vid_ok) begin
                  err_code <= ERR_VID;
                  error    <= 1'b1;
                  st       <= SQ_FAIL;
               end else if (!did_ok) begin
                  err_code <= ERR_DID;
                  error    <= 1'b1;
                  st       <= SQ_FAIL;
               end else begin
                  done <= 1'b1;
                  st   <= SQ_DONE;
               end
            end
            default: ;
         endcase
      end
   end

   AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && error)); // R10
   AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> done); // R10
   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      error |=> (error && $stable(err_code))); // R9
   AST_ERR_CODE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      error |-> (err_code != '0 && err_code <= ERR_DID)); // R9
endmodule

// File: rtl/txcfg_bringup.sv
module txcfg_bringup
   import txcfg_pkg::*;
#(
   parameter int          QTR_CYC   = 250,
   parameter logic [6:0]  TGT_ADDR  = 7'h38,
   parameter logic [7:0]  MODE_A    = 8'h35,
   parameter logic [7:0]  MODE_B    = 8'h16,
   parameter logic [7:0]  MODE_C    = 8'h80,
   parameter logic [15:0] EXP_VID   = 16'h014C,
   parameter logic [7:0]  EXP_DID   = 8'h10,
   parameter bit          CHECK_DID = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        pwr_good,
   input  logic        sda_in,
   output logic        scl_oe,
   output logic        sda_oe,
   output logic        tgt_rst_n,
   output logic        done,
   output logic        error,
   output logic [3:0]  err_code,
   output logic [15:0] vendor_id,
   output logic [7:0]  device_id
);
   logic       cmd_valid;
   i2c_op_e    cmd_op;
   logic [7:0] cmd_byte;
   logic       eng_busy, eng_done, eng_ack;
   logic [7:0] eng_rx;

   always_ff @(posedge clk) begin
      if (!rst_n)        tgt_rst_n <= 1'b0;
      else if (pwr_good) tgt_rst_n <= 1'b1;
   end

   txcfg_i2c_engine #(.QTR_CYC(QTR_CYC)) i_engine (
      .clk      (clk),
      .rst_n    (rst_n),
      .cmd_valid(cmd_valid),
      .cmd_op   (cmd_op),
      .cmd_byte (cmd_byte),
      .busy     (eng_busy),
      .done     (eng_done),
      .ack_ok   (eng_ack),
      .rx_byte  (eng_rx),
      .sda_in   (sda_in),
      .scl_oe   (scl_oe),
      .sda_oe   (sda_oe)
   );

   txcfg_script #(
      .TGT_ADDR (TGT_ADDR),
      .MODE_A   (MODE_A),
      .MODE_B   (MODE_B),
      .MODE_C   (MODE_C),
      .EXP_VID  (EXP_VID),
      .EXP_DID  (EXP_DID),
      .CHECK_DID(CHECK_DID)
   ) i_script (
      .clk      (clk),
      .rst_n    (rst_n),
      .go       (tgt_rst_n),
      .cmd_valid(cmd_valid),
      .cmd_op   (cmd_op),
      .cmd_byte (cmd_byte),
      .eng_done (eng_done),
      .eng_ack  (eng_ack),
      .eng_rx   (eng_rx),
      .done     (done),
      .error    (error),
      .err_code (err_code),
      .vendor_id(vendor_id),
      .device_id(device_id)
   );

   AST_BUS_QUIET_IN_RST: assert property (@(posedge clk) disable iff (!rst_n)
      !tgt_rst_n |-> (!scl_oe && !sda_oe)); // R1
   AST_REL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      tgt_rst_n |=> tgt_rst_n); // R1
   AST_IDLE_BUS_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
      (done || error) |-> (!scl_oe && !sda_oe)); // R10
   AST_BUSY_NOT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      eng_busy |-> !(done || error)); // R9
endmodule

// File: tb/test_txcfg_bringup.sv
module test_txcfg_bringup;
   localparam int QTR     = 5;
   localparam int SCL_PER = 4 * QTR;
   localparam logic [7:0] MA = 8'h35, MB = 8'h16, MC = 8'h80, DID = 8'h10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic pwr_good = 1'b0;
   logic scl_oe, sda_oe, tgt_rst_n, done, error;
   logic [3:0]  err_code;
   logic [15:0] vendor_id;
   logic [7:0]  device_id;
   logic s_oe = 1'b0;
   logic sda_line;

   always #5 clk = ~clk;
   assign sda_line = ~(sda_oe | s_oe);

   txcfg_bringup #(.QTR_CYC(QTR), .MODE_A(MA), .MODE_B(MB), .MODE_C(MC),
                   .EXP_VID(16'h014C), .EXP_DID(DID)) i_txcfg_bringup (
      .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .sda_in(sda_line),
      .scl_oe(scl_oe), .sda_oe(sda_oe), .tgt_rst_n(tgt_rst_n), .done(done),
      .error(error), .err_code(err_code), .vendor_id(vendor_id), .device_id(device_id));

   int checks = 0;
   int errors = 0;

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // scoreboard of expected register writes {sub, data}
   logic [15:0] exp_q[$];
   int          wr_seen = 0;

   task automatic expect_write(input logic [7:0] sub, input logic [7:0] dat);
      exp_q.push_back({sub, dat});
   endtask

   // target model state
   typedef enum int {T_IDLE, T_ADDR, T_WR, T_RD} tst_e;
   tst_e st = T_IDLE;
   logic [7:0] id0, id1, id2;
   int   nack_at = 0;
   int   addr_cnt = 0;
   int   n_start = 0, n_stop = 0, n_rstart = 0, n_mnack = 0, n_badaddr = 0;
   int   per_ok = 0, per_bad = 0;
   int   cyc = 0;
   int   last_rise = 0;
   int   bc = 0;
   bit   ack_ph = 0, rw = 0, wfirst = 0, mnack = 0;
   bit   scl_p = 1, sda_p = 1;
   logic [7:0] shr, rdb, ptr;

   always @(posedge clk) cyc++;

   function automatic logic [7:0] id_at(input logic [7:0] a);
      case (a)
         8'h00:   return id0;
         8'h01:   return id1;
         8'h02:   return id2;
         default: return 8'hEE;
      endcase
   endfunction

   always @(negedge clk) begin
      bit scl_l, sda_l;
      scl_l = ~scl_oe;
      sda_l = ~(sda_oe | s_oe);
      if (scl_p && scl_l && sda_p && !sda_l) begin
         n_start++;
         if (st != T_IDLE) n_rstart++;
         st = T_ADDR; bc = 0; ack_ph = 0; s_oe = 1'b0;
      end else if (scl_p && scl_l && !sda_p && sda_l) begin
         n_stop++;
         st = T_IDLE; s_oe = 1'b0;
      end else if (!scl_p && scl_l && st != T_IDLE) begin
         if (!ack_ph && bc >= 1 && bc < 8) begin
            if (cyc - last_rise == SCL_PER) per_ok++; else per_bad++;
         end
         last_rise = cyc;
         if (!ack_ph && bc < 8) begin
            if (st != T_RD) shr = {shr[6:0], sda_l};
            bc++;
         end else if (ack_ph && st == T_RD) begin
            mnack = sda_l;
         end
      end else if (scl_p && !scl_l && st != T_IDLE) begin
         if (!ack_ph && bc == 8) begin
            ack_ph = 1;
            if (st == T_RD) begin
               s_oe = 1'b0;
            end else if (st == T_ADDR) begin
               addr_cnt++;
               if (shr[7:1] != 7'h38) n_badaddr++;
               if (shr[7:1] == 7'h38 && addr_cnt != nack_at) begin
                  s_oe = 1'b1; rw = shr[0];
               end else begin
                  st = T_IDLE; s_oe = 1'b0;
               end
            end else begin
               s_oe = 1'b1;
               if (wfirst) ptr = shr;
               else begin
                  // monitor side of the scoreboard: R4 first write, R5 the rest
                  if (exp_q.size() == 0) begin
                     chk(0, (wr_seen == 0) ? "R4" : "R5", {16'h0, ptr, shr}, 32'h0);
                  end else begin
                     logic [15:0] e;
                     e = exp_q.pop_front();
                     chk({ptr, shr} == e, (wr_seen == 0) ? "R4" : "R5", {ptr, shr}, e);
                  end
                  wr_seen++;
               end
            end
         end else if (ack_ph) begin
            ack_ph = 0; bc = 0;
            if (st == T_ADDR) begin
               st = rw ? T_RD : T_WR; wfirst = 1;
            end else if (st == T_WR) begin
               wfirst = 0;
            end else if (mnack) begin
               n_mnack++; st = T_IDLE;
            end
            if (st == T_RD) begin
               rdb = id_at(ptr); ptr = ptr + 1'b1;
               s_oe = ~rdb[7];
            end else begin
               s_oe = 1'b0;
            end
         end else if (st == T_RD) begin
            s_oe = ~rdb[7 - bc];
         end
      end
      scl_p = scl_l;
      sda_p = sda_l;
   end

   task automatic run_case(input string name, input logic [7:0] lo, input logic [7:0] hi,
                           input logic [7:0] dv, input int nk, input int n_wr,
                           input int code, input int exp_st, input int exp_sp);
      int s0, p0, r0, m0, b0, pb0, busy_seen;
      logic [15:0] wl[4];
      wl[0] = {8'h08, 8'h01}; wl[1] = {8'h08, MA}; wl[2] = {8'h09, MB}; wl[3] = {8'h0A, MC};
      id0 = lo; id1 = hi; id2 = dv;
      rst_n = 1'b0; pwr_good = 1'b0;
      repeat (3) @(negedge clk);
      nack_at = (nk == 0) ? 0 : addr_cnt + nk;
      for (int i = 0; i < n_wr; i++) expect_write(wl[i][15:8], wl[i][7:0]);
      s0 = n_start; p0 = n_stop; r0 = n_rstart; m0 = n_mnack; b0 = n_badaddr; pb0 = per_bad;
      chk(!tgt_rst_n && !scl_oe && !sda_oe, "R1 reset state", {tgt_rst_n, scl_oe, sda_oe}, 0);
      chk(!done && !error, "R10 reset flags", {done, error}, 0);
      rst_n = 1'b1;
      busy_seen = 0;
      for (int i = 0; i < 50; i++) begin
         @(negedge clk);
         if (scl_oe || sda_oe || tgt_rst_n) busy_seen++;
      end
      chk(busy_seen == 0, "R1 hold before power good", busy_seen, 0);
      pwr_good = 1'b1;
      @(negedge clk); @(negedge clk);
      chk(tgt_rst_n, "R1 release", tgt_rst_n, 1);
      pwr_good = 1'b0;
      for (int i = 0; i < 30000 && !done && !error; i++) @(negedge clk);
      repeat (3) @(negedge clk);
      $display("case %s: done=%0b error=%0b code=%0d", name, done, error, err_code);
      chk(tgt_rst_n, "R1 stays released", tgt_rst_n, 1);
      chk(done == (code == 0), "R10 done", done, code == 0);
      chk(error == (code != 0), "R9 error", error, code != 0);
      chk(err_code == 4'(code), (code >= 8) ? "R8 code" : "R9 code", err_code, code);
      chk(!scl_oe && !sda_oe, "R10 bus released", {scl_oe, sda_oe}, 0);
      chk(n_start - s0 == exp_st, "R9 start count", n_start - s0, exp_st);
      chk(n_stop - p0 == exp_sp, "R9 stop count", n_stop - p0, exp_sp);
      chk(exp_q.size() == 0, "R5 all writes seen", exp_q.size(), 0);
      while (exp_q.size() != 0) void'(exp_q.pop_front());
      chk(n_badaddr == b0, "R3 address", n_badaddr - b0, 0);
      chk(per_bad == pb0, "R2 SCL period", per_bad - pb0, 0);
      if (code == 0 || code >= 8) begin
         chk(vendor_id == {hi, lo}, "R7 vendor", vendor_id, {hi, lo});
         chk(device_id == dv, "R7 device", device_id, dv);
         chk(n_rstart - r0 == 3, "R6 repeated start", n_rstart - r0, 3);
         chk(n_mnack - m0 == 3, "R6 master NACK", n_mnack - m0, 3);
      end
   endtask

   initial begin
      run_case("normal",     8'h4C, 8'h01, DID,   0, 4, 0, 10, 7);
      chk(per_ok > 0, "R2 periods measured", per_ok, 1);
      run_case("vendor_bad", 8'h4D, 8'h01, DID,   0, 4, 8, 10, 7);
      run_case("device_bad", 8'h4C, 8'h01, 8'h11, 0, 4, 9, 10, 7);
      run_case("nack_pwr",   8'h4C, 8'h01, DID,   1, 0, 1, 1, 1);
      run_case("nack_modeb", 8'h4C, 8'h01, DID,   3, 2, 3, 3, 3);
      run_case("nack_rdadr", 8'h4C, 8'h01, DID,   6, 4, 5, 6, 5);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule